// File: doc/BRIEF.md
# Activity Monitor with Watermark Interrupts

This block watches a single activity strobe and measures how busy it is over fixed sampling windows. Each cycle in which the strobe is high adds a programmable weight to an accumulator. When a window closes, the sum is latched as the window count and folded into an exponential moving average. The window length is a number of base ticks, and a base tick is a fixed number of clock cycles.

After each window, the count and the updated average are compared against upper and lower limits. A raw-count limit fires only after the count has stayed past it for a programmable number of consecutive windows. The average limits fire on the first window that crosses them. Each cause sets its own sticky status bit, which software clears by writing ones. An interrupt line and a global status bit report any pending cause whose enable is set.

Software uses the block through a word-addressed register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `amon_top`

## Requirements
- R1: After reset, the period register (address 1) reads 9, the control register (address 2) reads 0, the interrupt status register (address 11) reads 0, and `irq` is low.
- R2: With control bit 31 (run) and bit 18 (sampling) set, a window lasts (period register + 1) × TICK_CYCLES cycles. It starts in the cycle after the control write that sets run. At the end of the window, the count register (address 9) shows the sum, over the strobe-high cycles of that window, of the weight register (address 8).
- R3: The accumulated sum saturates at all ones and never wraps.
- R4: At each window end, the average (address 10) becomes avg + ((count − avg) >>> (K+1)), computed as a signed value. K is control bits 12:10.
- R5: A write to the seed register (address 5) loads the average at once, and the new value can be read at address 10.
- R6: If count > the raw upper limit (address 3) for N consecutive windows, status bit 31 is set, provided control bit 30 is set. N−1 is held in control bits 28:26. A window that does not qualify restarts the run, and so does a firing.
- R7: If count < the raw lower limit (address 4) for M consecutive windows, status bit 30 is set, provided control bit 29 is set. M−1 is held in control bits 25:23. The run restarts the same way as in R6.
- R8: If the updated average is greater than the average upper limit (address 6), status bit 24 is set, provided control bit 21 is set. If it is less than the average lower limit (address 7), status bit 25 is set, provided control bit 20 is set.
- R9: Status bits are sticky. Writing ones to address 11 clears exactly those bits. A set in the same cycle takes priority.
- R10: `irq` and global status bit 0 (address 0) are high exactly when some status bit is set and its enable is still set. Clearing an enable masks its bit without clearing it.
- R11: While control bit 31 is clear, strobes are not accumulated, the timer is held at zero, the consecutive-window runs are cleared, and the count and average do not change.
- R12: While control bit 18 is clear, no window is sampled: the count and average hold, and accumulation continues until the next sampled window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_strobe | input | 1 | Activity event for this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt, level |

## Verification
The assertions assume that software changes the consecutive-window fields and the period only while run is clear. They also assume that the seed value never goes past CNT_W bits, so the average always fits in its register. The stimulus keeps to both rules: every reconfiguration first writes the control register to zero, then programs the limits and the seed, and then sets run again. Strobes are driven only in whole windows aligned to that run edge, so each window's contents are known exactly.

// File: rtl/amon_pkg.sv
package amon_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    // Register word addresses
    localparam logic [ADDR_W-1:0] A_GSTAT  = 4'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 4'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd2;
    localparam logic [ADDR_W-1:0] A_RAW_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_RAW_LO = 4'd4;
    localparam logic [ADDR_W-1:0] A_SEED   = 4'd5;
    localparam logic [ADDR_W-1:0] A_AVG_HI = 4'd6;
    localparam logic [ADDR_W-1:0] A_AVG_LO = 4'd7;
    localparam logic [ADDR_W-1:0] A_WEIGHT = 4'd8;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd9;
    localparam logic [ADDR_W-1:0] A_AVG    = 4'd10;
    localparam logic [ADDR_W-1:0] A_ISTAT  = 4'd11;

    // Control word fields
    localparam int C_RUN    = 31;
    localparam int C_HI_EN  = 30;
    localparam int C_LO_EN  = 29;
    localparam int C_HI_N   = 26;
    localparam int C_LO_N   = 23;
    localparam int C_AHI_EN = 21;
    localparam int C_ALO_EN = 20;
    localparam int C_SAMPLE = 18;
    localparam int C_K      = 10;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'hFFB4_1C00;

    // Interrupt status bits
    localparam int S_HI  = 31;
    localparam int S_LO  = 30;
    localparam int S_ALO = 25;
    localparam int S_AHI = 24;
    localparam logic [DATA_W-1:0] STAT_MASK = 32'hC300_0000;
endpackage

// File: rtl/amon_timer.sv
// Window timer: counts base ticks of TICK_CYCLES cycles each and pulses
// win_end on the last cycle of a window of (period_m1+1) ticks.
// Assumes period_m1 is changed only while run is low.
module amon_timer #(
    parameter int TICK_CYCLES = 1000,
    parameter int PER_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] period_m1,
    output logic             win_end
);
    localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    logic [TW-1:0]    tick_q;
    logic [PER_W-1:0] ms_q;
    logic             tick;

    assign tick    = (tick_q == TW'(TICK_CYCLES - 1));
    assign win_end = run && tick && (ms_q >= period_m1);

    // Advance tick and window counters; hold both at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tick_q <= '0;
            ms_q   <= '0;
        end else if (tick) begin
            tick_q <= '0;
            ms_q   <= (ms_q >= period_m1) ? '0 : ms_q + PER_W'(1);
        end else begin
            tick_q <= tick_q + TW'(1);
        end
    end

    AST_TIMER_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (tick_q == '0 || run)) else $error("timer ran while stopped"); // R11
endmodule

// File: rtl/amon_avg.sv
// Exponential average: on sample, avg moves toward count by (count-avg)>>>(k+1).
// A seed write overrides the update in the same cycle.
module amon_avg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [CNT_W-1:0] count,
    input  logic [2:0]       k,
    input  logic             seed_wr,
    input  logic [CNT_W-1:0] seed_val,
    output logic [CNT_W-1:0] avg_q,
    output logic [CNT_W-1:0] avg_nx
);
    logic signed [CNT_W+1:0] diff, step, nx_full;

    // Signed filter step in a two-bit-wider accumulator.
    always_comb begin
        diff    = $signed({2'b00, count}) - $signed({2'b00, avg_q});
        step    = diff >>> ({1'b0, k} + 4'd1);
        nx_full = $signed({2'b00, avg_q}) + step;
        avg_nx  = nx_full[CNT_W-1:0];
    end

    // Register the average: seed first, then window update.
    always_ff @(posedge clk) begin
        if (!rst_n)       avg_q <= '0;
        else if (seed_wr) avg_q <= seed_val;
        else if (sample)  avg_q <= avg_nx;
    end

    AST_AVG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (nx_full[CNT_W+1:CNT_W] == 2'b00)) else $error("avg overflow"); // R4
    AST_AVG_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !seed_wr) |=>
        ((avg_q >= $past(avg_q) && avg_q <= $past(count)) ||
         (avg_q <= $past(avg_q) && avg_q >= $past(count)))) else $error("avg left range"); // R4
endmodule

// File: rtl/amon_run.sv
// Consecutive-window detector: hit pulses on the (need_m1+1)-th qualifying
// sample in a row; a non-qualifying sample or a hit restarts the run.
module amon_run #(
    parameter int NUM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sample,
    input  logic             qualify,
    input  logic [NUM_W-1:0] need_m1,
    output logic             hit
);
    logic [NUM_W-1:0] run_q;

    assign hit = sample && qualify && (run_q >= need_m1);

    // Track the length of the current qualifying run.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        run_q <= '0;
        else if (sample) begin
            if (!qualify || hit)  run_q <= '0;
            else                  run_q <= run_q + NUM_W'(1);
        end
    end

    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !qualify) |=> (run_q == '0)) else $error("run not restarted"); // R6
endmodule

// File: rtl/amon_top.sv
// Activity monitor: weighted strobe accumulation per window, moving average,
// raw and average limit checks with sticky write-one-to-clear status.
// Assumes CNT_W <= 32 and that run-length fields change only while stopped.
module amon_top
    import amon_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int TICK_CYCLES = 1000,
    parameter int PER_W       = 8,
    parameter int PER_RST     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_strobe,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [DATA_W-1:0] ctrl_q, stat_q, set_mask, clr_mask;
    logic [PER_W-1:0]  period_q;
    logic [CNT_W-1:0]  raw_hi_q, raw_lo_q, avg_hi_q, avg_lo_q, seed_q, weight_q;
    logic [CNT_W-1:0]  acc_q, count_q, acc_sat, avg_q, avg_nx;
    logic [CNT_W:0]    acc_sum;
    logic              run, win_end, sample, hi_hit, lo_hit, pend;

    assign run    = ctrl_q[C_RUN];
    assign sample = win_end && ctrl_q[C_SAMPLE];

    amon_timer #(.TICK_CYCLES(TICK_CYCLES), .PER_W(PER_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .run(run), .period_m1(period_q), .win_end(win_end));

    amon_avg #(.CNT_W(CNT_W)) avg_i (
        .clk(clk), .rst_n(rst_n), .sample(sample), .count(acc_sat),
        .k(ctrl_q[C_K+2:C_K]), .seed_wr(wr_en && wr_addr == A_SEED),
        .seed_val(wr_data[CNT_W-1:0]), .avg_q(avg_q), .avg_nx(avg_nx));

    amon_run #(.NUM_W(3)) hi_run_i (
        .clk(clk), .rst_n(rst_n), .clr(!run), .sample(sample),
        .qualify(acc_sat > raw_hi_q), .need_m1(ctrl_q[C_HI_N+2:C_HI_N]), .hit(hi_hit));

    amon_run #(.NUM_W(3)) lo_run_i (
        .clk(clk), .rst_n(rst_n), .clr(!run), .sample(sample),
        .qualify(acc_sat < raw_lo_q), .need_m1(ctrl_q[C_LO_N+2:C_LO_N]), .hit(lo_hit));

    // Saturating weighted sum including this cycle's strobe.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, (act_strobe ? weight_q : '0)};
        acc_sat = acc_sum[CNT_W] ? '1 : acc_sum[CNT_W-1:0];
    end

    // Accumulate while running; latch and restart at each sampled window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            count_q <= '0;
        end else if (run) begin
            if (sample) begin
                count_q <= acc_sat;
                acc_q   <= '0;
            end else begin
                acc_q   <= acc_sat;
            end
        end
    end

    // Status sets from the enabled causes at a sampled window end.
    always_comb begin
        set_mask = '0;
        set_mask[S_HI]  = hi_hit && ctrl_q[C_HI_EN];
        set_mask[S_LO]  = lo_hit && ctrl_q[C_LO_EN];
        set_mask[S_AHI] = sample && ctrl_q[C_AHI_EN] && (avg_nx > avg_hi_q);
        set_mask[S_ALO] = sample && ctrl_q[C_ALO_EN] && (avg_nx < avg_lo_q);
        clr_mask = (wr_en && wr_addr == A_ISTAT) ? wr_data : '0;
    end

    // Configuration registers and sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            period_q <= PER_W'(PER_RST);
            raw_hi_q <= '0;
            raw_lo_q <= '0;
            avg_hi_q <= '0;
            avg_lo_q <= '0;
            seed_q   <= '0;
            weight_q <= CNT_W'(1);
            stat_q   <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL:   ctrl_q   <= wr_data & CTRL_MASK;
                    A_PERIOD: period_q <= wr_data[PER_W-1:0];
                    A_RAW_HI: raw_hi_q <= wr_data[CNT_W-1:0];
                    A_RAW_LO: raw_lo_q <= wr_data[CNT_W-1:0];
                    A_AVG_HI: avg_hi_q <= wr_data[CNT_W-1:0];
                    A_AVG_LO: avg_lo_q <= wr_data[CNT_W-1:0];
                    A_SEED:   seed_q   <= wr_data[CNT_W-1:0];
                    A_WEIGHT: weight_q <= wr_data[CNT_W-1:0];
                    default: ;
                endcase
            end
            stat_q <= ((stat_q & ~clr_mask) | set_mask) & STAT_MASK;
        end
    end

    assign pend = (stat_q[S_HI]  && ctrl_q[C_HI_EN])  || (stat_q[S_LO]  && ctrl_q[C_LO_EN]) ||
                  (stat_q[S_AHI] && ctrl_q[C_AHI_EN]) || (stat_q[S_ALO] && ctrl_q[C_ALO_EN]);
    assign irq  = pend;

    // Combinational read mux.
    always_comb begin
        case (rd_addr)
            A_GSTAT:  rd_data = {31'd0, pend};
            A_PERIOD: rd_data = DATA_W'(period_q);
            A_CTRL:   rd_data = ctrl_q;
            A_RAW_HI: rd_data = DATA_W'(raw_hi_q);
            A_RAW_LO: rd_data = DATA_W'(raw_lo_q);
            A_SEED:   rd_data = DATA_W'(seed_q);
            A_AVG_HI: rd_data = DATA_W'(avg_hi_q);
            A_AVG_LO: rd_data = DATA_W'(avg_lo_q);
            A_WEIGHT: rd_data = DATA_W'(weight_q);
            A_COUNT:  rd_data = DATA_W'(count_q);
            A_AVG:    rd_data = DATA_W'(avg_q);
            A_ISTAT:  rd_data = stat_q;
            default:  rd_data = '0;
        endcase
    end

    AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count_q)) else $error("count moved while stopped"); // R11
    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sample) |=> (acc_q >= $past(acc_q))) else $error("accumulator wrapped"); // R3
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[S_HI] && !(wr_en && wr_addr == A_ISTAT && wr_data[S_HI])) |=> stat_q[S_HI])
        else $error("status bit dropped"); // R9
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_q != '0)) else $error("irq without status"); // R10
endmodule

// File: tb/amon_top_tb_top.sv
module amon_top_tb_top;
    localparam int TICK = 2;
    localparam int PERM1 = 3;
    localparam int L = (PERM1 + 1) * TICK;
    localparam logic [31:0] EN = 32'h8000_0000, HIE = 32'h4000_0000, LOE = 32'h2000_0000;
    localparam logic [31:0] AHE = 32'h0020_0000, ALE = 32'h0010_0000, SMP = 32'h0004_0000;
    localparam int NV = 8;
    localparam int EV [NV] = '{3, 8, 0, 5, 8, 1, 2, 7};

    logic clk = 1'b0, rst_n = 1'b0, act_strobe = 1'b0, wr_en = 1'b0, irq;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    int errors = 0, checks = 0;
    longint avg_m;

    always #2 clk = ~clk;

    amon_top #(.CNT_W(32), .TICK_CYCLES(TICK), .PER_W(8), .PER_RST(9)) dut_i (
        .clk(clk), .rst_n(rst_n), .act_strobe(act_strobe), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic win(input int e);
        for (int i = 0; i < L; i++) begin
            act_strobe = (i < e);
            @(negedge clk);
        end
        act_strobe = 1'b0;
    endtask

    function automatic longint next_avg(input longint a, input longint c, input int k);
        return a + ((c - a) >>> (k + 1));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        rd(4'd1, v); check("R1 period", v, 32'd9);
        rd(4'd2, v); check("R1 ctrl", v, 32'd0);
        rd(4'd11, v); check("R1 istat", v, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        @(negedge clk);

        // Table walk: R2 counts, R4 average, R5 seed
        wr(4'd1, PERM1);
        wr(4'd8, 32'd2);
        wr(4'd5, 32'd16);
        rd(4'd10, v); check("R5 seed", v, 32'd16);
        avg_m = 16;
        wr(4'd2, EN | SMP | (32'd1 << 10));
        for (int n = 0; n < NV; n++) begin
            win(EV[n]);
            avg_m = next_avg(avg_m, EV[n] * 2, 1);
            rd(4'd9, v); check("R2 count", v, 32'(EV[n] * 2));
            rd(4'd10, v); check("R4 avg", v, 32'(avg_m));
        end

        // R11 freeze while stopped
        wr(4'd2, 32'd0);
        act_strobe = 1'b1;
        repeat (20) @(negedge clk);
        act_strobe = 1'b0;
        rd(4'd9, v); check("R11 count held", v, 32'd14);
        rd(4'd10, v); check("R11 avg held", v, 32'(avg_m));
        wr(4'd2, EN | SMP | (32'd1 << 10));
        win(3);
        rd(4'd9, v); check("R11 no stale events", v, 32'd6);

        // R12 sampling off
        wr(4'd2, 32'd0);
        wr(4'd2, EN);
        win(5); win(5);
        rd(4'd9, v); check("R12 no sample", v, 32'd6);
        wr(4'd2, 32'd0);
        wr(4'd2, EN | SMP);
        win(0);
        rd(4'd9, v); check("R12 carried sum", v, 32'd20);

        // R3 saturation
        wr(4'd2, 32'd0);
        wr(4'd8, 32'hFFFF_FFFF);
        wr(4'd2, EN | SMP);
        win(2);
        rd(4'd9, v); check("R3 saturate", v, 32'hFFFF_FFFF);

        // R6 raw upper, N=2
        wr(4'd2, 32'd0);
        wr(4'd8, 32'd1);
        wr(4'd11, 32'hFFFF_FFFF);
        wr(4'd3, 32'd5);
        wr(4'd2, EN | SMP | HIE | (32'd1 << 26));
        win(6);
        rd(4'd11, v); check("R6 one window not enough", v, 32'd0);
        win(6);
        rd(4'd11, v); check("R6 upper fired", v, 32'h8000_0000);
        check("R10 irq on", {31'd0, irq}, 32'd1);
        rd(4'd0, v); check("R10 gstat on", v, 32'd1);
        wr(4'd2, EN | SMP | (32'd1 << 26));
        check("R10 masked irq", {31'd0, irq}, 32'd0);
        rd(4'd11, v); check("R10 bit kept", v, 32'h8000_0000);
        wr(4'd11, 32'h8000_0000);
        rd(4'd11, v); check("R9 cleared", v, 32'd0);

        // R6 run restart
        wr(4'd2, 32'd0);
        wr(4'd2, EN | SMP | HIE | (32'd1 << 26));
        win(6); win(2); win(6);
        rd(4'd11, v); check("R6 run restarted", v, 32'd0);
        win(6);
        rd(4'd11, v); check("R6 refired", v, 32'h8000_0000);
        wr(4'd2, 32'd0);
        wr(4'd11, 32'hFFFF_FFFF);

        // R7 raw lower, M=3
        wr(4'd4, 32'd2);
        wr(4'd2, EN | SMP | LOE | (32'd2 << 23));
        win(1); win(1);
        rd(4'd11, v); check("R7 two windows not enough", v, 32'd0);
        win(1);
        rd(4'd11, v); check("R7 lower fired", v, 32'h4000_0000);
        wr(4'd2, 32'd0);

        // R8 average upper, K=0
        wr(4'd8, 32'd4);
        wr(4'd5, 32'd0);
        wr(4'd6, 32'd10);
        wr(4'd2, EN | SMP | AHE);
        win(8);
        rd(4'd11, v); check("R8 avg upper", v, 32'h4100_0000);
        check("R10 irq from avg", {31'd0, irq}, 32'd1);
        wr(4'd11, 32'h4000_0000);
        rd(4'd11, v); check("R9 partial clear", v, 32'h0100_0000);
        wr(4'd2, 32'd0);
        wr(4'd11, 32'hFFFF_FFFF);
        rd(4'd11, v); check("R9 clear all", v, 32'd0);

        // R8 average lower
        wr(4'd5, 32'd100);
        wr(4'd7, 32'd60);
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd2, EN | SMP | ALE);
        win(0);
        rd(4'd10, v); check("R4 avg down", v, 32'd50);
        rd(4'd11, v); check("R8 avg lower", v, 32'h0200_0000);
        wr(4'd2, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule